// File: doc/BRIEF.md
# Audio Receiver Sample Error Concealment

This block sits between the decoder of a digital audio interface receiver and the processing that follows it. Each decoded 24-bit two's complement sample arrives with a valid strobe and two flags, one for a parity error and one for a biphase error, and a PLL lock indicator is sampled along with it. For every strobed sample the block emits one output sample a cycle later. It hides corrupted or unlocked data according to two static 2-bit policy inputs: one for flagged samples, one for loss of lock.

When lock is present, the error policy chooses one of three actions for a flagged sample: pass it, replace it with the last good sample, or replace it with zero. When lock is absent, the lock policy chooses pass, hold, zero or a soft mute. In the soft mute the held sample decays by halving until it reaches silence. A sample becomes the "last good" reference only if it arrived with lock present and with no error flag. Loss-of-lock handling overrides the error policy whenever its policy is anything other than pass.

Top module: `audio_conceal`

## Requirements
- R1: Each cycle with `in_valid` high is followed, one cycle later, by `out_valid` high for exactly one cycle. `out_valid` is low after every cycle without a strobe. `out_data` changes only in the cycle after a strobe.
- R2: With lock present, error policy 2'b00 passes a flagged sample unchanged. The reserved code 2'b11 behaves exactly like 2'b00.
- R3: With lock present, error policy 2'b01 replaces a sample flagged with a parity or biphase error by the last good sample.
- R4: With lock present, error policy 2'b10 replaces a flagged sample by zero.
- R5: The last good sample is updated only by a strobed sample with `locked` high and both error flags low. Flagged or unlocked samples leave it unchanged.
- R6: With lock absent and lock policy 2'b00, lock loss has no effect: the sample passes, and the error policy still applies to its flags.
- R7: With lock absent, lock policy 2'b01 outputs the last good sample on every strobe.
- R8: With lock absent, lock policy 2'b10 outputs zero on every strobe.
- R9: With lock absent, lock policy 2'b11 soft-mutes. The first unlocked strobe outputs the last good sample with its magnitude halved, rounded toward zero. Each further unlocked strobe halves the previous output the same way, so the output reaches 0 and stays there.
- R10: When lock is absent and the lock policy is not 2'b00, the lock action is taken regardless of the error flags and the error policy.
- R11: A strobe with lock present ends any soft mute and is handled normally. The next unlocked run under 2'b11 restarts its decay from the last good sample.
- R12: Reset (active low, asynchronous) clears `out_valid` and `out_data` and sets the last good sample to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 24 | Decoded sample, two's complement |
| in_par_err | input | 1 | Parity error flag for this sample |
| in_bip_err | input | 1 | Biphase error flag for this sample |
| locked | input | 1 | PLL lock indicator |
| err_mode | input | 2 | Policy for flagged samples (00 pass, 01 hold, 10 zero, 11 pass) |
| lock_mode | input | 2 | Policy while unlocked (00 pass, 01 hold, 10 zero, 11 soft mute) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Concealed sample |

## Verification
Two functions can act on the same sample: a sample can carry an error flag and also arrive while lock is absent. The bench drives such samples with the error flags set and an error policy that would give a different result. The output is judged correct only if it matches the lock action: the held sample, zero, or the decay step. A second coincidence arises when a flagged sample under the hold policy follows a good one. The output must then show the previous reference, while the good sample must have updated that reference without a cycle of delay.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned MODE_W   = 2;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_ZERO  = 2'd2,
    ACT_DECAY = 2'd3
  } act_e;

  localparam logic [MODE_W-1:0] ERRP_HOLD  = 2'b01;
  localparam logic [MODE_W-1:0] ERRP_ZERO  = 2'b10;
  localparam logic [MODE_W-1:0] LCKP_PASS  = 2'b00;
  localparam logic [MODE_W-1:0] LCKP_HOLD  = 2'b01;
  localparam logic [MODE_W-1:0] LCKP_ZERO  = 2'b10;
  localparam logic [MODE_W-1:0] LCKP_DECAY = 2'b11;
endpackage

// File: rtl/conceal_classify.sv
module conceal_classify
  import conceal_pkg::*;
(
  input  logic              locked,
  input  logic              par_err,
  input  logic              bip_err,
  input  logic [MODE_W-1:0] err_mode,
  input  logic [MODE_W-1:0] lock_mode,
  output act_e              act,
  output logic              good
);
  logic flagged;

  always_comb begin
    flagged = par_err | bip_err;
    good    = locked & ~flagged;
    act     = ACT_PASS;
    if (!locked && (lock_mode != LCKP_PASS)) begin
      unique case (lock_mode)
        LCKP_HOLD:  act = ACT_HOLD;
        LCKP_ZERO:  act = ACT_ZERO;
        LCKP_DECAY: act = ACT_DECAY;
        default:    act = ACT_PASS;
      endcase
    end else if (flagged) begin
      unique case (err_mode)
        ERRP_HOLD: act = ACT_HOLD;
        ERRP_ZERO: act = ACT_ZERO;
        default:   act = ACT_PASS;
      endcase
    end
  end
endmodule

// File: rtl/conceal_hold.sv
module conceal_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] ref_q
);
  logic [W-1:0] ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load_en) ref_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  AST_REF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ref_q)); // R5
  AST_REF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ref_q == $past(load_data))); // R5
endmodule

// File: rtl/conceal_decay.sv
module conceal_decay #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         clear_en,
  input  logic [W-1:0] seed,
  output logic [W-1:0] next_val
);
  logic         active_q, active_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] base;
  logic [W-1:0] biased;

  function automatic logic [W:0] mag(input logic [W-1:0] v);
    logic [W:0] ext;
    ext = {v[W-1], v};
    return v[W-1] ? (~ext + 1'b1) : ext;
  endfunction

  // Halve toward zero: bias negatives by one before the arithmetic shift
  always_comb begin
    base     = active_q ? acc_q : seed;
    biased   = base + {{(W-1){1'b0}}, base[W-1]};
    next_val = {biased[W-1], biased[W-1:1]};
  end

  always_comb begin
    active_d = active_q;
    acc_d    = acc_q;
    if (step_en) begin
      active_d = 1'b1;
      acc_d    = next_val;
    end else if (clear_en) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      acc_q    <= '0;
    end else begin
      active_q <= active_d;
      acc_q    <= acc_d;
    end
  end

  AST_DECAY_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && active_q) |=> (mag(acc_q) <= mag($past(acc_q)))); // R9
  AST_DECAY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en && !step_en) |=> !active_q); // R11
endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
  import conceal_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  input  logic              in_par_err,
  input  logic              in_bip_err,
  input  logic              locked,
  input  logic [MODE_W-1:0] err_mode,
  input  logic [MODE_W-1:0] lock_mode,
  output logic              out_valid,
  output logic [W-1:0]      out_data
);
  act_e         act;
  logic         good;
  logic [W-1:0] ref_q;
  logic [W-1:0] decay_val;
  logic         step_en, clear_en, load_en;
  logic [W-1:0] data_d;
  logic         valid_q;
  logic [W-1:0] data_q;

  conceal_classify i_classify (
    .locked   (locked),
    .par_err  (in_par_err),
    .bip_err  (in_bip_err),
    .err_mode (err_mode),
    .lock_mode(lock_mode),
    .act      (act),
    .good     (good)
  );

  always_comb begin
    load_en  = in_valid & good;
    step_en  = in_valid & (act == ACT_DECAY);
    clear_en = in_valid & (act != ACT_DECAY);
  end

  conceal_hold #(.W(W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_data(in_data),
    .ref_q    (ref_q)
  );

  conceal_decay #(.W(W)) i_decay (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .clear_en(clear_en),
    .seed    (ref_q),
    .next_val(decay_val)
  );

  always_comb begin
    data_d = data_q;
    if (in_valid) begin
      unique case (act)
        ACT_HOLD:  data_d = ref_q;
        ACT_ZERO:  data_d = '0;
        ACT_DECAY: data_d = decay_val;
        default:   data_d = in_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_STROBE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data))); // R1
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && locked && (in_par_err || in_bip_err) && err_mode == ERRP_ZERO)
      |=> (out_data == '0)); // R4
  AST_LOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !locked && lock_mode == LCKP_ZERO) |=> (out_data == '0)); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !locked && lock_mode == LCKP_HOLD) |=> (out_data == $past(ref_q))); // R7
  AST_LOCK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_par_err && !in_bip_err && (locked || lock_mode == LCKP_PASS))
      |=> (out_data == $past(in_data))); // R6
endmodule

// File: tb/test_audio_conceal.sv
`timescale 1ns/1ps
module test_audio_conceal;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_data;
  logic        in_par_err, in_bip_err, locked;
  logic [1:0]  err_mode, lock_mode;
  logic        out_valid;
  logic [23:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_conceal i_audio_conceal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_par_err(in_par_err), .in_bip_err(in_bip_err), .locked(locked),
    .err_mode(err_mode), .lock_mode(lock_mode),
    .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct packed {
    logic        lk;
    logic        pe;
    logic        be;
    logic [1:0]  em;
    logic [1:0]  lm;
    logic [23:0] d;
    logic [23:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,2'b00,2'b00,24'h000100,24'h000100,8'd2},  // R2 clean pass, ref=0x100
    '{1'b1,1'b1,1'b0,2'b00,2'b00,24'h123456,24'h123456,8'd2},  // R2 flagged, no action
    '{1'b1,1'b0,1'b1,2'b11,2'b00,24'h0ABCDE,24'h0ABCDE,8'd2},  // R2 reserved code
    '{1'b1,1'b1,1'b0,2'b01,2'b00,24'h777777,24'h000100,8'd3},  // R3 hold
    '{1'b1,1'b0,1'b0,2'b01,2'b00,24'hFFF000,24'hFFF000,8'd5},  // R5 new ref
    '{1'b1,1'b0,1'b1,2'b01,2'b00,24'h111111,24'hFFF000,8'd3},  // R3 hold new ref
    '{1'b1,1'b1,1'b1,2'b10,2'b00,24'h222222,24'h000000,8'd4},  // R4 zero
    '{1'b0,1'b0,1'b0,2'b00,2'b00,24'h333333,24'h333333,8'd6},  // R6 unlocked pass
    '{1'b0,1'b1,1'b0,2'b01,2'b00,24'h999999,24'hFFF000,8'd6},  // R6 error policy still acts
    '{1'b1,1'b1,1'b0,2'b01,2'b00,24'h444444,24'hFFF000,8'd5},  // R5 unlocked not latched
    '{1'b0,1'b0,1'b0,2'b00,2'b01,24'h555555,24'hFFF000,8'd7},  // R7 hold
    '{1'b0,1'b1,1'b0,2'b10,2'b01,24'h666666,24'hFFF000,8'd10}, // R10 lock beats error zero
    '{1'b0,1'b1,1'b0,2'b01,2'b10,24'h121212,24'h000000,8'd8},  // R8 zero, R10
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h7FFFFF,24'hFFF800,8'd9},  // R9 -4096 -> -2048
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h7FFFFF,24'hFFFC00,8'd9},  // R9
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h7FFFFF,24'hFFFE00,8'd9},  // R9
    '{1'b1,1'b0,1'b0,2'b00,2'b11,24'h000005,24'h000005,8'd11}, // R11 lock back, ref=5
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'h000002,8'd11}, // R11 restart from 5
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'h000001,8'd9},  // R9
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'h000000,8'd9},  // R9 reaches zero
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'h000000,8'd9},  // R9 stays zero
    '{1'b1,1'b0,1'b0,2'b00,2'b00,24'hFFFFFD,24'hFFFFFD,8'd5},  // R5 ref=-3
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'hFFFFFF,8'd9},  // R9 -3 -> -1
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'h000000,8'd9},  // R9 -1 -> 0
    '{1'b1,1'b0,1'b0,2'b00,2'b00,24'h800000,24'h800000,8'd5},  // R5 ref=most negative
    '{1'b0,1'b1,1'b1,2'b10,2'b11,24'h000000,24'hC00000,8'd9},  // R9 R10 flags ignored
    '{1'b1,1'b1,1'b0,2'b00,2'b11,24'h0F0F0F,24'h0F0F0F,8'd11}, // R11 locked flagged pass
    '{1'b0,1'b0,1'b0,2'b00,2'b11,24'h000000,24'hC00000,8'd11}  // R11 restart from ref
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string tag);
    @(negedge clk);
    in_valid = 1'b1; locked = v.lk; in_par_err = v.pe; in_bip_err = v.be;
    err_mode = v.em; lock_mode = v.lm; in_data = v.d;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {23'd0, out_valid}, 24'd1);
    chk(tag, out_data, v.e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_par_err = 1'b0; in_bip_err = 1'b0;
    locked = 1'b1; err_mode = 2'b00; lock_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R12 reset valid", {23'd0, out_valid}, 24'd0);
    chk("R12 reset data", out_data, 24'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i], $sformatf("R%0d row %0d", TBL[i].req, i));
    end
    // R1: idle cycles keep strobe low and data steady
    repeat (2) @(negedge clk);
    chk("R1 idle valid", {23'd0, out_valid}, 24'd0);
    chk("R1 idle data", out_data, 24'hC00000);
    // R12: reference cleared by reset
    do_reset();
    apply('{1'b1,1'b1,1'b0,2'b01,2'b00,24'hABCDEF,24'h000000,8'd12}, "R12 ref zero hold");
    apply('{1'b0,1'b0,1'b0,2'b00,2'b11,24'hABCDEF,24'h000000,8'd12}, "R12 ref zero decay");
    apply('{1'b0,1'b0,1'b0,2'b00,2'b01,24'hABCDEF,24'h000000,8'd7},  "R7 ref zero hold");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule